// File: doc/BRIEF.md
# Scaled-Counter PWM Timer

This block is a pulse-width modulation timer with several output channels that all share one free-running counter. The counter is wider than the comparators. A 4-bit shift setting picks which 16-bit slice of the counter reaches the comparators, so the period is a power of two, 2^(16+shift) clock cycles. Each channel compares that slice with its own 16-bit threshold. Its pin is driven low while the slice is below the threshold and high once the slice reaches it. A threshold of zero keeps the pin high for the whole period. Even the largest threshold still leaves one high step per period, so the pin can never stay low for the full period.

Software reaches the block through a simple word-wide register port. There is a mode word, a counter register that can be loaded, a read-only view of the shifted slice, and one threshold word per channel. The counter runs in one of two ways. In continuous mode it counts until software stops it. In single-pass mode it counts up to the end of the period, where the single-pass bit clears itself and the counter stops at zero. A further mode ends the period early, as soon as the slice reaches the threshold of channel 0.

Each channel has a pending flag that is set while its compare match holds. The flag is either refreshed every cycle or latched until software writes it to zero. Thresholds have no shadow copy: a write changes the outputs on the very next cycle. Three further mode bits are stored and read back but have no effect on behaviour. One asks for symmetric (centre) counting, one asks for pairing of channels, and one asks for glitch filtering.

Top module: `sctimer_pwm`

## Requirements
- R1: Register offsets: mode word at 0x00, counter at 0x08, shifted slice at 0x10, and the threshold of channel i at 0x20+4*i in bits 15:0. Mode word fields: shift in bits 3:0, latch-pending in bit 8, early-period-end in bit 9, glitch filter in bit 10, continuous run in bit 12, single pass in bit 13, centre in bit 16, pairing in bit 24, and the pending flag of channel i in bit 28+i. Each field reads back what was last written, except where R5 and R8 to R9 change it.
- R2: The register at 0x10 reads counter bits [shift+15:shift], zero-extended.
- R3: While bit 12 or bit 13 is set, the counter rises by one each cycle. While neither is set, the counter holds its value.
- R4: When the low 16+shift bits of the running counter are all ones, the counter becomes 0 on the next cycle, including any higher bits.
- R5: In single-pass mode, the cycle that ends the period also clears bit 13. The counter then stays at 0 unless bit 12 is set.
- R6: With bit 9 set, a running counter whose slice is greater than or equal to threshold 0 becomes 0 on the next cycle.
- R7: pwm_n[i] is 1 when the slice is greater than or equal to threshold i, and 0 otherwise. A threshold of 0 keeps the pin at 1. A threshold of 0xFFFF leaves the pin at 1 only when the slice is 0xFFFF.
- R8: With bit 8 clear, pending flag i equals the compare match of channel i one cycle earlier.
- R9: With bit 8 set, a pending flag stays 1 once set until a mode word write stores 0 into it.
- R10: A threshold write changes the pin on the cycle after the write edge.
- R11: A write to 0x08 loads the counter, and the load wins over counting in that cycle.
- R12: After reset, every register reads 0, every pending flag is 0 and every pin is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of register |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_n | output | 4 | Channel outputs, low while the slice is below the threshold |
| irq_pend | output | 4 | Pending flags, same as mode word bits 31:28 |

## Verification
Random counter values, shifts and thresholds exercise the slice and the comparators. These show whether the shift selects the right bits and whether the compare is greater-or-equal rather than strict. Directed runs load the counter just short of the end of a period, in continuous, single-pass and early-end modes. These show whether the counter is cleared at the right cycle and whether it stops or carries on afterwards. Pending flags are driven through a match that appears and then disappears, once with latching and once without, which separates a flag that follows the match from one that holds it. Extreme thresholds, 0 and 0xFFFF, expose errors in the pin polarity and at the comparison boundary.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int CMP_W   = 16;
  localparam int SCALE_W = 4;
  localparam int CNT_W   = CMP_W + (1 << SCALE_W) - 1;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;

  localparam int A_CFG    = 'h00;
  localparam int A_CNT    = 'h08;
  localparam int A_SLICE  = 'h10;
  localparam int A_THR    = 'h20;
  localparam int THR_STEP = 4;

  localparam int B_LATCH  = 8;
  localparam int B_EARLY  = 9;
  localparam int B_FILT   = 10;
  localparam int B_CONT   = 12;
  localparam int B_ONCE   = 13;
  localparam int B_CENTRE = 16;
  localparam int B_PAIR   = 24;
  localparam int B_PEND   = 28;

  function automatic logic [CMP_W-1:0] slice_of(logic [CNT_W-1:0] c, logic [SCALE_W-1:0] s);
    logic [CNT_W-1:0] t;
    t = c >> s;
    return t[CMP_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] period_mask(logic [SCALE_W-1:0] s);
    logic [CNT_W:0] one, m;
    one = {{CNT_W{1'b0}}, 1'b1};
    m = (one << (CMP_W + int'(s))) - one;
    return m[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/sct_counter.sv
module sct_counter
  import sct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] shift,
  input  logic               early_en,
  input  logic               thr0_hit,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   cnt,
  output logic [CMP_W-1:0]   slice,
  output logic               wrap_evt
);
  logic [CNT_W-1:0] mask;
  logic             natural_end;

  assign mask        = period_mask(shift);
  assign natural_end = (cnt & mask) == mask;
  assign wrap_evt    = run && (natural_end || (early_en && thr0_hit));
  assign slice       = slice_of(cnt, shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (wrap_evt) cnt <= '0;
    else if (run)      cnt <= cnt + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !wrap_evt) |=> cnt == $past(cnt) + 1'b1);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load) |=> cnt == '0);
  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/sct_channel.sv
module sct_channel
  import sct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic [CMP_W-1:0] thr_wdata,
  input  logic [CMP_W-1:0] slice,
  input  logic             latch,
  input  logic             pend_wr,
  input  logic             pend_wdata,
  output logic [CMP_W-1:0] thr_q,
  output logic             match,
  output logic             pend,
  output logic             pin
);
  assign match = slice >= thr_q;
  assign pin   = match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (thr_wr) thr_q <= thr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_wr) pend <= pend_wdata;
    else if (latch)   pend <= pend | match;
    else              pend <= match;
  end

  // R8
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !pend_wr) |=> pend == $past(match));
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !pend_wr && pend) |=> pend);
endmodule

// File: rtl/sctimer_pwm.sv
module sctimer_pwm
  import sct_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_n,
  output logic [NCH-1:0]    irq_pend
);
  logic [SCALE_W-1:0] shift_q;
  logic latch_q, early_q, filt_q, cont_q, once_q, centre_q, pair_q;
  logic cfg_wr, cnt_wr, run, wrap_evt;
  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] slice;
  logic [NCH-1:0]   match, thr_wr;
  logic [CMP_W-1:0] thr_q [NCH];

  assign cfg_wr = bus_wr && bus_addr == ADDR_W'(A_CFG);
  assign cnt_wr = bus_wr && bus_addr == ADDR_W'(A_CNT);
  assign run    = cont_q || once_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0; latch_q <= 1'b0; early_q <= 1'b0; filt_q <= 1'b0;
      cont_q <= 1'b0; once_q <= 1'b0; centre_q <= 1'b0; pair_q <= 1'b0;
    end else if (cfg_wr) begin
      shift_q  <= bus_wdata[SCALE_W-1:0];
      latch_q  <= bus_wdata[B_LATCH];
      early_q  <= bus_wdata[B_EARLY];
      filt_q   <= bus_wdata[B_FILT];
      cont_q   <= bus_wdata[B_CONT];
      once_q   <= bus_wdata[B_ONCE];
      centre_q <= bus_wdata[B_CENTRE];
      pair_q   <= bus_wdata[B_PAIR];
    end else if (wrap_evt) begin
      once_q   <= 1'b0;
    end
  end

  sct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .shift(shift_q),
    .early_en(early_q), .thr0_hit(match[0]), .load(cnt_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .cnt(cnt), .slice(slice), .wrap_evt(wrap_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign thr_wr[i] = bus_wr && bus_addr == ADDR_W'(A_THR + i * THR_STEP);
    sct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr[i]),
      .thr_wdata(bus_wdata[CMP_W-1:0]), .slice(slice), .latch(latch_q),
      .pend_wr(cfg_wr), .pend_wdata(bus_wdata[B_PEND+i]),
      .thr_q(thr_q[i]), .match(match[i]), .pend(irq_pend[i]), .pin(pwm_n[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CFG)) begin
      bus_rdata[SCALE_W-1:0] = shift_q;
      bus_rdata[B_LATCH]  = latch_q;
      bus_rdata[B_EARLY]  = early_q;
      bus_rdata[B_FILT]   = filt_q;
      bus_rdata[B_CONT]   = cont_q;
      bus_rdata[B_ONCE]   = once_q;
      bus_rdata[B_CENTRE] = centre_q;
      bus_rdata[B_PAIR]   = pair_q;
      bus_rdata[B_PEND +: NCH] = irq_pend;
    end else if (bus_addr == ADDR_W'(A_CNT)) begin
      bus_rdata[CNT_W-1:0] = cnt;
    end else if (bus_addr == ADDR_W'(A_SLICE)) begin
      bus_rdata[CMP_W-1:0] = slice;
    end
    for (int k = 0; k < NCH; k++)
      if (bus_addr == ADDR_W'(A_THR + k * THR_STEP))
        bus_rdata[CMP_W-1:0] = thr_q[k];
  end

  // R5
  once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !cfg_wr) |=> !once_q);
  // R6
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && early_q && match[0] && !cnt_wr) |=> bus_addr != ADDR_W'(A_CNT) || bus_rdata == '0);
endmodule

// File: tb/test_sctimer_pwm.sv
module test_sctimer_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_n, irq_pend;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int CONT = 1 << 12, ONCE = 1 << 13, EARLY = 1 << 9, LATCH = 1 << 8;

  sctimer_pwm i_sctimer_pwm (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic longint exp_slice(longint c, int s);
    return (c / (longint'(1) << s)) % 65536;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(13));
    repeat (3) @(negedge clk);
    // R12 reset state
    rd('h00, v); chk("R12 cfg", v, 0);
    rd('h08, v); chk("R12 cnt", v, 0);
    rd('h24, v); chk("R12 thr", v, 0);
    chk("R12 pins", pwm_n, 4'hF);
    chk("R12 pend", irq_pend, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 field readback (non-running fields)
    wr('h00, 32'h0101_0405);
    rd('h00, v); chk("R1 cfg readback", v & 32'h0fff_ffff, 32'h0101_0405);
    wr('h2C, 32'h0000_1234);
    rd('h2C, v); chk("R1 thr3 readback", v, 32'h1234);
    wr('h00, 0);

    // R2 / R11 random slice reads, R7 random pins
    for (int n = 0; n < 20; n++) begin
      longint c; int s; logic [15:0] t;
      c = longint'({$urandom} & 32'h7fff_ffff);
      s = int'($urandom % 16);
      t = 16'($urandom);
      if (n % 4 == 0) t = 16'(exp_slice(c, s));
      wr('h00, 32'(s));
      wr('h08, 32'(c));
      wr('h24, {16'h0, t});
      rd('h08, v); chk("R11 load", v, c);
      rd('h10, v); chk("R2 slice", v, exp_slice(c, s));
      chk("R7 pin1", pwm_n[1], (exp_slice(c, s) >= t) ? 1 : 0);
    end

    // R7 extremes, R10 immediate threshold
    wr('h00, 0);
    wr('h08, 32'hFFFE);
    wr('h28, 32'hFFFF);
    chk("R7 ffff below", pwm_n[2], 0);
    chk("R7 zero thr", pwm_n[0], 1);
    wr('h08, 32'hFFFF);
    chk("R7 ffff at top", pwm_n[2], 1);
    wr('h28, 32'h0);
    chk("R10 thr applies", pwm_n[2], 1);
    wr('h08, 32'h10);
    wr('h28, 32'h11);
    chk("R10 thr applies low", pwm_n[2], 0);

    // R3 counting and hold
    wr('h08, 32'h1000);
    wr('h00, CONT);
    repeat (7) @(negedge clk);
    rd('h08, v); chk("R3 count", v, 32'h1007);
    wr('h00, 0);
    rd('h08, v);
    repeat (4) @(negedge clk);
    begin logic [31:0] w; rd('h08, w); chk("R3 hold", w, v); end

    // R4 natural end with shift 2
    wr('h00, 2);
    wr('h08, 32'h0004_0000 | 32'h3FFFD);
    wr('h00, CONT | 2);
    repeat (2) @(negedge clk);
    rd('h10, v); chk("R4 top slice", v, 32'hFFFF);
    @(negedge clk);
    rd('h08, v); chk("R4 wrap to zero", v, 0);
    @(negedge clk);
    rd('h08, v); chk("R4 continues", v, 1);

    // R5 single pass
    wr('h00, 0);
    wr('h08, 32'h1FFFD);
    wr('h00, ONCE);
    repeat (3) @(negedge clk);
    rd('h08, v); chk("R5 wrap", v, 0);
    rd('h00, v); chk("R5 once cleared", v[13], 0);
    repeat (5) @(negedge clk);
    rd('h08, v); chk("R5 stopped", v, 0);

    // R6 early end at threshold 0
    wr('h20, 100);
    wr('h08, 97);
    wr('h00, CONT | EARLY);
    repeat (3) @(negedge clk);
    rd('h08, v); chk("R6 reach", v, 100);
    @(negedge clk);
    rd('h08, v); chk("R6 reset", v, 0);
    wr('h00, 0);
    wr('h20, 0);

    // R8 pending follows match
    wr('h08, 50);
    wr('h24, 40);
    @(negedge clk);
    chk("R8 pend set", irq_pend[1], 1);
    wr('h24, 60);
    @(negedge clk);
    chk("R8 pend drops", irq_pend[1], 0);

    // R9 latched pending
    wr('h00, LATCH);
    wr('h24, 40);
    @(negedge clk);
    wr('h24, 60);
    repeat (2) @(negedge clk);
    chk("R9 pend held", irq_pend[1], 1);
    rd('h00, v); chk("R1 pend bit29", v[29], 1);
    wr('h00, LATCH);
    @(negedge clk);
    chk("R9 pend cleared", irq_pend[1], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule